// File: doc/BRIEF.md
# RAM Write Protection Guard

This block stands on the write paths of two bus masters, a CPU and a coprocessor, that share one RAM. Software programs two address windows through a small register port: a coprocessor-private window and a shared window. It also sets a control register that holds a protection enable, an interrupt enable and a sticky violation flag. While protection is off, every write request passes through unchanged. While protection is on, the block gates each master's write enable in the same cycle. The CPU may not write into the coprocessor-private window. The coprocessor may write only inside its private window or the shared window.

A CPU write attempt that the block suppresses sets the violation flag one clock later. Software clears the flag by writing 1 to it. An interrupt line is raised whenever both the flag and the interrupt enable are set. Suppressed coprocessor writes are gated in the same way but never touch the flag. Once protection is enabled, the window bound registers are frozen, so the protected layout cannot be altered until protection is turned off again.

Top module: `ram_wr_guard`

## Requirements
- R1: Register select 0 is the control register: bit 3 is the protection enable, bit 1 the interrupt enable and bit 0 the violation flag. It resets to 0, and bits 7..4 and bit 2 always read 0. Selects 1..4 are the coprocessor window low and high bounds and the shared window low and high bounds, all resetting to 0. Selects 5..7 read 0 and ignore writes.
- R2: With the enable clear, `cpu_wr_ok` equals `cpu_wr_req` and `cop_wr_ok` equals `cop_wr_req` for any address.
- R3: With the enable set, a CPU write request whose address lies in the coprocessor window gives `cpu_wr_ok`=0 in the same cycle. CPU requests at other addresses pass.
- R4: With the enable set, a coprocessor write request whose address lies in neither the coprocessor window nor the shared window gives `cop_wr_ok`=0 in the same cycle. Requests inside either window pass.
- R5: Writes to the four bound registers take effect on the next clock only while the enable is clear. While the enable is set, they leave the bounds unchanged.
- R6: A CPU write request that is suppressed under R3 sets the violation flag on the next clock. Suppressed coprocessor writes and requests made with the enable clear leave the flag unchanged.
- R7: Writing the control register with bit 0 set clears the flag on the next clock. Writing it with bit 0 clear leaves the flag unchanged.
- R8: If a CPU violation and a flag clear occur in the same cycle, the flag is 1 after the clock.
- R9: `irq` is 1 exactly when the interrupt enable and the violation flag are both 1.
- R10: Window bounds are inclusive: an address is inside a window when low <= address <= high. A window whose low bound exceeds its high bound contains no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data for the selected register (combinational) |
| cpu_wr_req | input | 1 | CPU write request |
| cpu_addr | input | ADDR_W | CPU write address |
| cpu_wr_ok | output | 1 | Gated CPU write enable |
| cop_wr_req | input | 1 | Coprocessor write request |
| cop_addr | input | ADDR_W | Coprocessor write address |
| cop_wr_ok | output | 1 | Gated coprocessor write enable |
| viol_flag | output | 1 | Sticky CPU violation flag |
| irq | output | 1 | Violation interrupt |

## Verification
Directed addresses probe each window edge and the addresses one below and one above it. These tests separate inclusive comparisons from exclusive or off-by-one ones, and they show which window gates which master. Random traffic with protection both on and off mixes CPU and coprocessor requests with register writes. The addresses are drawn mostly near the programmed bounds. This traffic tells the gated paths from the pass-through path and shows whether bound writes are locked. A CPU violation issued in the same cycle as a flag clear, and control writes that leave bit 0 at zero, separate set-priority from clear-priority and check that the flag is truly write-one-to-clear.

// File: rtl/ram_wr_guard_pkg.sv
package ram_wr_guard_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_COP_LO = 3'd1,
        SEL_COP_HI = 3'd2,
        SEL_SHR_LO = 3'd3,
        SEL_SHR_HI = 3'd4
    } reg_sel_e;

    localparam int BIT_EN     = 3;
    localparam int BIT_IE     = 1;
    localparam int BIT_FLAG   = 0;
    localparam int NUM_BOUNDS = 4;
    localparam int NUM_CHECKS = 3;

endpackage

// File: rtl/region_match.sv
module region_match #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit
);
    // inclusive window test; an inverted window matches nothing
    assign hit = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/wp_regs.sv
module wp_regs
    import ram_wr_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we,
    input  logic [2:0]                       reg_sel,
    input  logic [ADDR_W-1:0]                reg_wdata,
    input  logic                             cpu_viol,
    output logic                             en,
    output logic                             ie,
    output logic                             flag,
    output logic [NUM_BOUNDS-1:0][ADDR_W-1:0] bnd,
    output logic [ADDR_W-1:0]                rdata
);
    typedef struct packed {
        logic                              en;
        logic                              ie;
        logic                              flag;
        logic [NUM_BOUNDS-1:0][ADDR_W-1:0] bnd;
    } st_t;

    st_t  st_d, st_q;
    logic ctrl_wr;
    logic flag_clr;

    always_comb begin
        st_d     = st_q;
        ctrl_wr  = reg_we && (reg_sel == SEL_CTRL);
        flag_clr = ctrl_wr && reg_wdata[BIT_FLAG];
        if (ctrl_wr) begin
            st_d.en = reg_wdata[BIT_EN];
            st_d.ie = reg_wdata[BIT_IE];
        end
        for (int i = 0; i < NUM_BOUNDS; i++) begin
            if (reg_we && !st_q.en && (reg_sel == 3'(i + 1))) begin
                st_d.bnd[i] = reg_wdata;
            end
        end
        // a new violation takes priority over a clear
        st_d.flag = cpu_viol | (st_q.flag & ~flag_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel)
            SEL_CTRL: begin
                rdata[BIT_EN]   = st_q.en;
                rdata[BIT_IE]   = st_q.ie;
                rdata[BIT_FLAG] = st_q.flag;
            end
            SEL_COP_LO: rdata = st_q.bnd[0];
            SEL_COP_HI: rdata = st_q.bnd[1];
            SEL_SHR_LO: rdata = st_q.bnd[2];
            SEL_SHR_HI: rdata = st_q.bnd[3];
            default:    rdata = '0;
        endcase
    end

    assign en   = st_q.en;
    assign ie   = st_q.ie;
    assign flag = st_q.flag;
    assign bnd  = st_q.bnd;

    p_bounds_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |=> $stable(st_q.bnd));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_viol |=> st_q.flag);

    p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_CTRL && reg_wdata[BIT_FLAG] && !cpu_viol) |=> !st_q.flag);

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !(reg_we && reg_sel == SEL_CTRL && reg_wdata[BIT_FLAG])) |=> st_q.flag);
endmodule

// File: rtl/ram_wr_guard.sv
module ram_wr_guard
    import ram_wr_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              cpu_wr_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_wr_ok,
    input  logic              cop_wr_req,
    input  logic [ADDR_W-1:0] cop_addr,
    output logic              cop_wr_ok,
    output logic              viol_flag,
    output logic              irq
);
    logic                              en, ie, flag, cpu_viol;
    logic [NUM_BOUNDS-1:0][ADDR_W-1:0] bnd;
    logic [NUM_CHECKS-1:0][ADDR_W-1:0] chk_addr, chk_lo, chk_hi;
    logic [NUM_CHECKS-1:0]             hit;

    // check 0: CPU vs coprocessor window, 1: coprocessor vs own window,
    // 2: coprocessor vs shared window
    always_comb begin
        chk_addr = {cop_addr, cop_addr, cpu_addr};
        chk_lo   = {bnd[2], bnd[0], bnd[0]};
        chk_hi   = {bnd[3], bnd[1], bnd[1]};
    end

    for (genvar g = 0; g < NUM_CHECKS; g++) begin : g_chk
        region_match #(.ADDR_W(ADDR_W)) u_match (
            .addr (chk_addr[g]),
            .lo   (chk_lo[g]),
            .hi   (chk_hi[g]),
            .hit  (hit[g])
        );
    end

    assign cpu_viol  = en & cpu_wr_req & hit[0];
    assign cpu_wr_ok = cpu_wr_req & ~cpu_viol;
    assign cop_wr_ok = cop_wr_req & ~(en & ~hit[1] & ~hit[2]);
    assign viol_flag = flag;
    assign irq       = ie & flag;

    wp_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .cpu_viol  (cpu_viol),
        .en        (en),
        .ie        (ie),
        .flag      (flag),
        .bnd       (bnd),
        .rdata     (reg_rdata)
    );

    p_pass_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (cpu_wr_ok == cpu_wr_req) && (cop_wr_ok == cop_wr_req));

    p_cpu_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cpu_wr_req && cpu_addr >= bnd[0] && cpu_addr <= bnd[1]) |-> !cpu_wr_ok);

    p_cop_own_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_wr_req && cop_addr >= bnd[0] && cop_addr <= bnd[1]) |-> cop_wr_ok);

    p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_flag) |-> $past(cpu_wr_req && !cpu_wr_ok));

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> viol_flag);
endmodule

// File: tb/sim_ram_wr_guard.sv
module sim_ram_wr_guard;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          cpu_wr_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_wr_ok;
    logic          cop_wr_req = 1'b0;
    logic [AW-1:0] cop_addr = '0;
    logic          cop_wr_ok;
    logic          viol_flag;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    // reference state
    logic          m_en = 0, m_ie = 0, m_fl = 0;
    logic [AW-1:0] m_b [4] = '{default: '0};

    always #10 clk = ~clk;

    ram_wr_guard #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_wr_req(cpu_wr_req), .cpu_addr(cpu_addr), .cpu_wr_ok(cpu_wr_ok),
        .cop_wr_req(cop_wr_req), .cop_addr(cop_addr), .cop_wr_ok(cop_wr_ok),
        .viol_flag(viol_flag), .irq(irq)
    );

    function automatic logic inside_w(logic [AW-1:0] a, logic [AW-1:0] lo, logic [AW-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic [AW-1:0] exp_rdata(logic [2:0] s);
        case (s)
            3'd0: return AW'({m_en, 1'b0, m_ie, m_fl});
            3'd1: return m_b[0];
            3'd2: return m_b[1];
            3'd3: return m_b[2];
            3'd4: return m_b[3];
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_cpu_ok(logic rq, logic [AW-1:0] a);
        return rq && !(m_en && inside_w(a, m_b[0], m_b[1]));
    endfunction

    function automatic logic exp_cop_ok(logic rq, logic [AW-1:0] a);
        return rq && !(m_en && !inside_w(a, m_b[0], m_b[1]) && !inside_w(a, m_b[2], m_b[3]));
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare combinational and state outputs, update model at posedge
    task automatic step(input logic we, input logic [2:0] sel, input logic [AW-1:0] wd,
                        input logic creq, input logic [AW-1:0] ca,
                        input logic oreq, input logic [AW-1:0] oa);
        logic set_v;
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = wd;
        cpu_wr_req = creq; cpu_addr = ca; cop_wr_req = oreq; cop_addr = oa;
        #1;
        chk("R1/R5 reg_rdata", reg_rdata, exp_rdata(sel));
        chk(m_en ? "R3/R10 cpu_wr_ok" : "R2 cpu_wr_ok", AW'(cpu_wr_ok), AW'(exp_cpu_ok(creq, ca)));
        chk(m_en ? "R4/R10 cop_wr_ok" : "R2 cop_wr_ok", AW'(cop_wr_ok), AW'(exp_cop_ok(oreq, oa)));
        chk("R6/R7/R8 viol_flag", AW'(viol_flag), AW'(m_fl));
        chk("R9 irq", AW'(irq), AW'(m_ie & m_fl));
        set_v = m_en && creq && inside_w(ca, m_b[0], m_b[1]);
        @(posedge clk);
        if (we && sel == 3'd0) begin
            m_fl = set_v | (m_fl & ~wd[0]);
            m_en = wd[3];
            m_ie = wd[1];
        end else begin
            if (we && sel >= 3'd1 && sel <= 3'd4 && !m_en) m_b[sel - 1] = wd;
            m_fl = set_v | m_fl;
        end
    endtask

    task automatic idle(input logic [2:0] sel);
        step(0, sel, '0, 0, '0, 0, '0);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        int k = int'($urandom_range(0, 9));
        if (k < 8) return m_b[k % 4] + AW'(int'($urandom_range(0, 2)) - 1);
        return AW'($urandom());
    endfunction

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset contents of every select
        for (int s = 0; s < 8; s++) idle(3'(s));
        // R1: reserved control bits read 0
        step(1, 3'd0, 16'h00F4, 0, '0, 0, '0);
        idle(3'd0);

        // program windows while disabled (R5): coprocessor 0x1000..0x1FFF, shared 0x2000..0x20FF
        step(1, 3'd1, 16'h1000, 0, '0, 0, '0);
        step(1, 3'd2, 16'h1FFF, 0, '0, 0, '0);
        step(1, 3'd3, 16'h2000, 0, '0, 0, '0);
        step(1, 3'd4, 16'h20FF, 0, '0, 0, '0);
        step(1, 3'd7, 16'hBEEF, 0, '0, 0, '0);
        idle(3'd7);

        // R2: disabled, protected addresses pass and no flag
        step(0, 3'd0, '0, 1, 16'h1000, 1, 16'h8000);
        idle(3'd0);

        // enable with interrupt enable
        step(1, 3'd0, 16'h000A, 0, '0, 0, '0);
        // R5: bound write ignored while enabled
        step(1, 3'd1, 16'h0005, 0, '0, 0, '0);
        idle(3'd1);

        // R3/R10: edges of coprocessor window for the CPU
        step(0, 3'd0, '0, 1, 16'h0FFF, 0, '0);
        idle(3'd0);
        step(0, 3'd0, '0, 1, 16'h1000, 0, '0);   // R6: sets flag, R9: irq
        idle(3'd0);
        // R7: write with bit 0 clear keeps flag
        step(1, 3'd0, 16'h000A, 1, 16'h2000, 0, '0);
        idle(3'd0);
        // R7: write 1 clears
        step(1, 3'd0, 16'h000B, 0, '0, 0, '0);
        idle(3'd0);
        // R8: violation and clear together
        step(1, 3'd0, 16'h000B, 1, 16'h1FFF, 0, '0);
        idle(3'd0);
        step(1, 3'd0, 16'h000B, 0, '0, 0, '0);

        // R4/R10: coprocessor window edges, no flag from coprocessor (R6)
        step(0, 3'd0, '0, 0, '0, 1, 16'h0FFF);
        step(0, 3'd0, '0, 0, '0, 1, 16'h1000);
        step(0, 3'd0, '0, 0, '0, 1, 16'h20FF);
        step(0, 3'd0, '0, 0, '0, 1, 16'h2100);
        idle(3'd0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            logic [2:0]    s  = 3'($urandom_range(0, 7));
            logic [AW-1:0] wd;
            if (r < 6) begin
                s  = 3'd0;
                wd = AW'($urandom()) & 16'h000B;
                if ($urandom_range(0, 3) != 0) wd[3] = 1'b1;
            end else if (r < 14) begin
                wd = AW'($urandom());
            end else begin
                wd = '0;
            end
            step(r < 14, s, wd, 1'($urandom()), pick_addr(), 1'($urandom()), pick_addr());
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule